// File: doc/BRIEF.md
# HI/LO multiply-accumulate unit

This unit executes the integer multiply family for a 32-bit RISC core. It keeps a 64-bit accumulator split into two 32-bit halves. HI holds the upper half and LO holds the lower half. A request carries two 32-bit operands and a 3-bit operation code. The unit can overwrite the accumulator with the product, add the product to it, or subtract the product from it. Each of these has a signed and an unsigned form.

A request is accepted when `start_i` is high, the unit is idle, and the code is one of the six defined operations. The multiply is iterative and retires one multiplier bit per cycle. While it runs, `busy_o` is high. The 64-bit result is written to HI and LO together at the edge that raises `done_o`. Until that edge, the read ports keep returning the previous accumulator contents.

Top module: `mac_hilo_unit`

## Requirements
- R1: `hi_o` always shows accumulator bits 63:32 and `lo_o` shows bits 31:0. Every result is split back into the two halves at that same boundary.
- R2: Code 0 (signed multiply) sign-extends both operands to 64 bits and writes the 64-bit product to HI:LO.
- R3: Code 1 (unsigned multiply) zero-extends both operands and writes the 64-bit product to HI:LO.
- R4: Code 2 (signed multiply-add) adds the signed 64-bit product to the current HI:LO.
- R5: Code 3 (unsigned multiply-add) adds the unsigned 64-bit product to the current HI:LO.
- R6: Code 4 (signed multiply-subtract) and code 5 (unsigned multiply-subtract) subtract the product from the current HI:LO.
- R7: Accumulate and subtract results wrap modulo 2^64, and no flag of any kind is raised.
- R8: After an accepted start, `busy_o` is high for exactly 32 cycles. `done_o` is then high for one cycle. HI and LO change only at the edge that raises `done_o`, and during busy they read the previous values.
- R9: When `rst_ni` is low, HI, LO, `busy_o` and `done_o` are all cleared to zero (asynchronous reset).
- R10: Codes 6 and 7 are ignored: the unit does not go busy, does not raise done, and leaves HI and LO unchanged.
- R11: A start request made while `busy_o` is high is ignored, and the operation already running completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation (accepted only when idle) |
| op_i | input | 3 | Operation code: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; HI and LO hold the new result |
| hi_o | output | 32 | Accumulator bits 63:32 |
| lo_o | output | 32 | Accumulator bits 31:0 |

## Verification
The hardest case to reach is a wrap across the full 64-bit range with a value that carries meaning in the accumulator. Random operands almost never land on it. The stimulus builds the state on purpose. It first loads the largest unsigned square and then adds the same square again. It also subtracts from a zero accumulator and multiplies the most negative operand by itself. A second start is injected partway through a busy period to show that the running operation keeps its own operands. After these directed cases, a long run of random codes, including the two undefined ones, is compared cycle by cycle against a behavioural model.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [1:0] {
    ACC_SET = 2'd0,
    ACC_ADD = 2'd1,
    ACC_SUB = 2'd2
  } acc_mode_e;

  typedef struct packed {
    logic      valid;
    logic      is_signed;
    acc_mode_e mode;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [OP_W-1:0] op);
    op_dec_t d;
    d.valid     = (op <= 3'd5);
    d.is_signed = ~op[0];
    unique case (op)
      3'd2, 3'd3: d.mode = ACC_ADD;
      3'd4, 3'd5: d.mode = ACC_SUB;
      default:    d.mode = ACC_SET;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/mac_opdec.sv
module mac_opdec
  import mac_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_dec_t         dec_o
);
  always_comb dec_o = decode_op(op_i);
endmodule

// File: rtl/mac_iter_mult.sv
module mac_iter_mult #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           fin_o,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW    = 2 * W;
  localparam int unsigned CNT_W = $clog2(W);

  logic [PW-1:0]    mcand_q, acc_q, sum_next;
  logic [W-1:0]     mplier_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q;
  logic             a_neg, b_neg;
  logic [W-1:0]     a_mag, b_mag;

  // operate on magnitudes, restore the sign at the end
  always_comb begin
    a_neg = signed_i & a_i[W-1];
    b_neg = signed_i & b_i[W-1];
    a_mag = a_neg ? (~a_i + W'(1)) : a_i;
    b_mag = b_neg ? (~b_i + W'(1)) : b_i;
  end

  assign fin_o    = busy_o && (cnt_q == CNT_W'(W - 1));
  assign sum_next = acc_q + (mplier_q[0] ? mcand_q : '0);
  assign prod_o   = neg_q ? (~sum_next + PW'(1)) : sum_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      neg_q    <= 1'b0;
    end else if (busy_o) begin
      acc_q    <= sum_next;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      if (fin_o) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end else if (start_i) begin
      busy_o   <= 1'b1;
      cnt_q    <= '0;
      mcand_q  <= {{W{1'b0}}, a_mag};
      mplier_q <= b_mag;
      acc_q    <= '0;
      neg_q    <= a_neg ^ b_neg;
    end
  end

  p_fin_drops_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
  p_start_loads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cnt_q == '0));
  p_run_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fin_o) |=> busy_o);
endmodule

// File: rtl/mac_hilo_acc.sv
module mac_hilo_acc
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  acc_mode_e      mode_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o,
  output logic           done_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] hilo_q, hilo_d;

  always_comb begin
    unique case (mode_i)
      ACC_ADD: hilo_d = hilo_q + prod_i;
      ACC_SUB: hilo_d = hilo_q - prod_i;
      default: hilo_d = prod_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hilo_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) hilo_q <= hilo_d;
    end
  end

  assign hi_o = hilo_q[PW-1:W];
  assign lo_o = hilo_q[W-1:0];

  p_hold_unless_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hilo_q));
  p_done_follows_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> done_o);
endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      hi_o,
  output logic [W-1:0]      lo_o
);
  localparam int unsigned PW = 2 * W;

  op_dec_t       dec;
  acc_mode_e     mode_q;
  logic          accept, fin;
  logic [PW-1:0] prod;

  mac_opdec i_dec (.op_i(op_i), .dec_o(dec));

  assign accept = start_i && !busy_o && dec.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= ACC_SET;
    else if (accept) mode_q <= dec.mode;
  end

  mac_iter_mult #(.W(W)) i_mult (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .signed_i (dec.is_signed),
    .a_i      (a_i),
    .b_i      (b_i),
    .busy_o   (busy_o),
    .fin_o    (fin),
    .prod_o   (prod)
  );

  mac_hilo_acc #(.W(W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fin),
    .mode_i (mode_q),
    .prod_i (prod),
    .hi_o   (hi_o),
    .lo_o   (lo_o),
    .done_o (done_o)
  );

  p_ignore_bad_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i > 3'd5) |=> (!busy_o && !done_o));
  p_busy_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/test_mac_hilo_unit.sv
module test_mac_hilo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mac_hilo_unit i_mac_hilo_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  // behavioural reference
  logic [63:0] m_acc = '0;
  logic        m_busy = 1'b0, m_done = 1'b0;
  int          m_cnt = 0;
  logic [2:0]  m_op;
  logic [31:0] m_a, m_b;

  function automatic logic [63:0] ref_result(input logic [2:0] o, input logic [31:0] x,
                                             input logic [31:0] y, input logic [63:0] cur);
    logic [63:0] p;
    if (o[0] == 1'b0) p = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
    else              p = {32'b0, x} * {32'b0, y};
    if (o <= 3'd1)      return p;
    else if (o <= 3'd3) return cur + p;
    else                return cur - p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = '0; m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          m_acc  = ref_result(m_op, m_a, m_b, m_acc);
        end
      end else if (start && op <= 3'd5) begin
        m_busy = 1'b1; m_cnt = 0; m_op = op; m_a = a; m_b = b;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-cycle compare
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
    if (rst_n) begin
      chk("R1 hi", {32'b0, hi}, {32'b0, m_acc[63:32]});
      chk("R1 lo", {32'b0, lo}, {32'b0, m_acc[31:0]});
      chk("R8 busy", {63'b0, busy}, {63'b0, m_busy});
      chk("R8 done", {63'b0, done}, {63'b0, m_done});
    end
  end

  task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    issue(o, x, y);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset hi/lo", {hi, lo}, 64'h0);
    chk("R9 reset busy/done", {62'b0, busy, done}, 64'h0);
    rst_n = 1'b1;

    run(3'd0, 32'hFFFF_FFFF, 32'd1);
    chk("R2 mult -1*1", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 multu max", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
    run(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R5 R7 maddu wrap", {hi, lo}, 64'hFFFF_FFFC_0000_0002);
    run(3'd0, 32'h8000_0000, 32'h8000_0000);
    chk("R2 mult min*min", {hi, lo}, 64'h4000_0000_0000_0000);
    run(3'd2, 32'd2, 32'd3);
    chk("R4 madd", {hi, lo}, 64'h4000_0000_0000_0006);
    run(3'd4, 32'd1, 32'd7);
    chk("R6 msub", {hi, lo}, 64'h3FFF_FFFF_FFFF_FFFF);
    run(3'd0, 32'd0, 32'd5);
    run(3'd5, 32'd1, 32'd1);
    chk("R6 R7 msubu wrap", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd2, 32'hFFFF_FFFF, 32'd1);
    chk("R4 madd negative", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFE);

    // R10: undefined codes ignored
    issue(3'd6, 32'd9, 32'd9);
    chk("R10 code 6 no busy", {63'b0, busy}, 64'h0);
    repeat (3) @(negedge clk);
    chk("R10 code 6 no change", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFE);
    issue(3'd7, 32'd9, 32'd9);
    repeat (3) @(negedge clk);
    chk("R10 code 7 no change", {62'b0, busy, done}, 64'h0);

    // R11: start during busy ignored; R8 old value during busy
    issue(3'd1, 32'd10, 32'd20);
    repeat (4) @(negedge clk);
    chk("R8 old value while busy", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFE);
    issue(3'd0, 32'd3, 32'd3);
    while (!done) @(negedge clk);
    chk("R11 first op kept", {hi, lo}, 64'd200);
    @(negedge clk);
    chk("R8 done one cycle", {62'b0, busy, done}, 64'h0);

    // random sweep, checked against the model each cycle
    for (int i = 0; i < 40; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      if (o > 3'd5) begin
        issue(o, $urandom, $urandom);
        @(negedge clk);
      end else begin
        run(o, $urandom, $urandom);
        chk("R1 random vs model", {hi, lo}, m_acc);
      end
    end

    // R9: asynchronous reset mid-operation
    issue(3'd1, 32'd7, 32'd7);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", {hi, lo, 30'b0, busy, done}, 96'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule